// File: doc/BRIEF.md
# Predicted-Reference Read-Retry Sequencer

This block sits in a flash controller and chooses the read reference code for each multi-level-cell page read. It holds a single predicted code for every erase block. A foreground page read starts at that prediction. If the ECC stage reports that the page could not be corrected, the read is reissued at a lower code, and this repeats until the page decodes or a limit is reached. A baseline sweep mode starts every read at a fixed top code instead, so that retry counts can be compared with the predicted mode.

A periodic tick starts a background pass that visits every block in turn. For each block, the pass walks downward from the current prediction. It keeps the code that gave the fewest ECC errors, and it writes that code back as the block's new prediction. Foreground reads always win arbitration. The background pass is only ever between two of its own reads when it yields, and it then resumes exactly where it stopped. The flash array, the ECC decoder and the voltage generator are outside the block. They are reached through a one-read-at-a-time port that carries a block number and a reference code, and a result return that carries pass/fail and an error count.

Top module: `vref_retry_seq`

## Requirements
- R1: After reset, every block's prediction equals INIT_CODE (default 160) until a background pass rewrites it.
- R2: A predicted-mode request (`req_sweep`=0) makes its first read on the requested block at that block's current prediction.
- R3: After a foreground result with `res_ok`=0 that ends neither by limit nor by floor, the next read is for the same block, at exactly STEP (default 4) below the previous code. A foreground retry never raises the code.
- R4: A foreground read ends in failure (`done_ok`=0) when `res_ok`=0 arrives and either the retry count already equals MAX_RETRY (default 40), or the current code minus STEP would drop below FLOOR (default 16). No read is ever issued below FLOOR.
- R5: A sweep-mode request (`req_sweep`=1) makes its first read at SWEEP_TOP (default 252) and then steps exactly as in R3 and R4.
- R6: `done_valid` pulses for one cycle, the cycle after the result that ends a foreground read. `done_retries` is the number of reads minus one, and `done_code` is the code of the last read.
- R7: `bg_tick` while no pass is running starts a pass over blocks 0 to NUM_BLOCKS-1 in ascending order, and `bg_busy` rises the next cycle. A tick while a pass is running is ignored.
- R8: For each block, the pass starts at the block's prediction and steps down by STEP. It tracks the code with the strictly lowest `res_errs`, so the earlier code wins a tie. The block's scan ends after two consecutive strict rises in `res_errs`, or when the next code would fall below FLOOR. The tracked code then becomes the block's prediction.
- R9: When `req_valid` is high at the moment a background result returns, the next read issued is the foreground one. The pass later continues at the same block and code.
- R10: At most one read is outstanding. `rd_valid` is a single-cycle pulse, and no new read is issued before the result of the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Foreground page read request, held until accepted |
| req_block | input | BLK_W | Block number of the request |
| req_sweep | input | 1 | 1 = baseline sweep from SWEEP_TOP, 0 = start at prediction |
| req_ready | output | 1 | High when a request is accepted this cycle |
| bg_tick | input | 1 | Periodic trigger for a background pass |
| bg_busy | output | 1 | A background pass is in progress |
| rd_valid | output | 1 | One-cycle read issue to the flash port |
| rd_bg | output | 1 | Issued read belongs to the background pass |
| rd_block | output | BLK_W | Block of the issued read |
| rd_code | output | CODE_W | Reference code of the issued read |
| res_valid | input | 1 | One-cycle result from the ECC stage |
| res_ok | input | 1 | 1 = page corrected, 0 = uncorrectable |
| res_errs | input | ERR_W | Raw error count reported by the ECC stage |
| done_valid | output | 1 | Foreground read completed |
| done_ok | output | 1 | Completed read decoded successfully |
| done_retries | output | RTY_W | Retries used by the completed read |
| done_code | output | CODE_W | Code of the final read attempt |

## Verification
The assertions take for granted that the result port follows the read port. Exactly one `res_valid` pulse must arrive for each `rd_valid`, no earlier than the cycle after it, and a request must stay stable until it is accepted. The bench keeps to these assumptions by acting as a single-slot flash model. It answers each issued read after a fixed latency and raises a new request only when no foreground read is in flight. The error counts it returns come from a per-block optimum and stay within the error-count width, so the rise and tie rules of the background scan see the same values that the reference model sees.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FG_LOOK,
    ST_BG_LOOK,
    ST_ISSUE,
    ST_WAIT
  } vrr_state_e;

endpackage

// File: rtl/vrr_pred_table.sv
// One predicted reference code per block. Simple dual-port RAM with a
// registered read; a valid vector supplies the reset value per entry.
module vrr_pred_table #(
  parameter int NUM_BLOCKS = 8,
  parameter int CODE_W     = 8,
  parameter int INIT_CODE  = 160,
  parameter int FLOOR      = 16,
  parameter int BLK_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  rd_addr,
  output logic [CODE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_addr,
  input  logic [CODE_W-1:0] wr_data
);

  localparam logic [CODE_W-1:0] INIT_C  = INIT_CODE[CODE_W-1:0];
  localparam logic [CODE_W-1:0] FLOOR_C = FLOOR[CODE_W-1:0];

  logic [CODE_W-1:0]     mem [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] vld;
  logic [CODE_W-1:0]     q;
  logic                  q_vld;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      q_vld <= 1'b0;
    end else begin
      if (wr_en) vld[wr_addr] <= 1'b1;
      q_vld <= vld[rd_addr];
    end
  end

  assign rd_data = q_vld ? q : INIT_C;

  AST_PRED_WRITE_FLOOR: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_data >= FLOOR_C); // R8

endmodule

// File: rtl/vrr_step_down.sv
// Next lower reference code and the floor test for the current code.
module vrr_step_down #(
  parameter int CODE_W = 8,
  parameter int STEP   = 4,
  parameter int FLOOR  = 16
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              floor_o
);

  localparam int                LIMIT_I = FLOOR + STEP;
  localparam logic [CODE_W:0]   LIMIT_C = LIMIT_I[CODE_W:0];
  localparam logic [CODE_W-1:0] STEP_C  = STEP[CODE_W-1:0];

  assign code_o  = code_i - STEP_C;
  assign floor_o = ({1'b0, code_i} < LIMIT_C);

endmodule

// File: rtl/vrr_bg_tracker.sv
// Best-code tracking for one block of the background scan.
module vrr_bg_tracker #(
  parameter int CODE_W = 8,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  logic              first_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ERR_W-1:0]  errs_i,
  output logic [CODE_W-1:0] best_o,
  output logic              stop_o
);

  logic [CODE_W-1:0] best, best_c;
  logic [ERR_W-1:0]  best_e, best_e_c, prev_e;
  logic [1:0]        rises, rises_c;

  always_comb begin
    if (first_i) begin
      best_c   = code_i;
      best_e_c = errs_i;
      rises_c  = 2'd0;
    end else begin
      if (errs_i < best_e) begin
        best_c   = code_i;
        best_e_c = errs_i;
      end else begin
        best_c   = best;
        best_e_c = best_e;
      end
      if (errs_i > prev_e) rises_c = rises + 2'd1;
      else                 rises_c = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best   <= '0;
      best_e <= '0;
      prev_e <= '0;
      rises  <= 2'd0;
    end else if (upd_i) begin
      best   <= best_c;
      best_e <= best_e_c;
      prev_e <= errs_i;
      rises  <= rises_c;
    end
  end

  assign best_o = best_c;
  assign stop_o = (rises_c == 2'd2);

  AST_BEST_NO_WORSE: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !first_i) |=> best_e <= $past(best_e)); // R8

endmodule

// File: rtl/vref_retry_seq.sv
module vref_retry_seq
  import vrr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int CODE_W     = 8,
  parameter int ERR_W      = 8,
  parameter int STEP       = 4,
  parameter int FLOOR      = 16,
  parameter int MAX_RETRY  = 40,
  parameter int INIT_CODE  = 160,
  parameter int SWEEP_TOP  = 252,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int RTY_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BLK_W-1:0]  req_block,
  input  logic              req_sweep,
  output logic              req_ready,
  input  logic              bg_tick,
  output logic              bg_busy,
  output logic              rd_valid,
  output logic              rd_bg,
  output logic [BLK_W-1:0]  rd_block,
  output logic [CODE_W-1:0] rd_code,
  input  logic              res_valid,
  input  logic              res_ok,
  input  logic [ERR_W-1:0]  res_errs,
  output logic              done_valid,
  output logic              done_ok,
  output logic [RTY_W-1:0]  done_retries,
  output logic [CODE_W-1:0] done_code
);

  localparam int                LAST_I  = NUM_BLOCKS - 1;
  localparam logic [BLK_W-1:0]  LAST_B  = LAST_I[BLK_W-1:0];
  localparam logic [RTY_W-1:0]  MAX_C   = MAX_RETRY[RTY_W-1:0];
  localparam logic [CODE_W-1:0] TOP_C   = SWEEP_TOP[CODE_W-1:0];
  localparam logic [CODE_W-1:0] FLOOR_C = FLOOR[CODE_W-1:0];

  vrr_state_e        state;
  logic [CODE_W-1:0] cur_code;
  logic [BLK_W-1:0]  cur_blk;
  logic              is_bg;
  logic              fg_sweep;
  logic [RTY_W-1:0]  fg_rty;

  logic              bg_active;
  logic [BLK_W-1:0]  bg_blk;
  logic [CODE_W-1:0] bg_code;
  logic              bg_first;

  logic [BLK_W-1:0]  tbl_raddr;
  logic [CODE_W-1:0] tbl_q;
  logic              tbl_we;
  logic [CODE_W-1:0] nxt_code;
  logic              at_floor;
  logic              trk_upd;
  logic [CODE_W-1:0] trk_best;
  logic              trk_stop;
  logic              res_here;

  assign res_here  = (state == ST_WAIT) && res_valid;
  assign trk_upd   = res_here && is_bg;
  assign tbl_we    = trk_upd && (trk_stop || at_floor);
  assign tbl_raddr = (state == ST_IDLE && req_valid) ? req_block : bg_blk;

  vrr_pred_table #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .CODE_W     (CODE_W),
    .INIT_CODE  (INIT_CODE),
    .FLOOR      (FLOOR),
    .BLK_W      (BLK_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (tbl_raddr),
    .rd_data (tbl_q),
    .wr_en   (tbl_we),
    .wr_addr (cur_blk),
    .wr_data (trk_best)
  );

  vrr_step_down #(
    .CODE_W (CODE_W),
    .STEP   (STEP),
    .FLOOR  (FLOOR)
  ) u_step (
    .code_i  (cur_code),
    .code_o  (nxt_code),
    .floor_o (at_floor)
  );

  vrr_bg_tracker #(
    .CODE_W (CODE_W),
    .ERR_W  (ERR_W)
  ) u_track (
    .clk     (clk),
    .rst     (rst),
    .upd_i   (trk_upd),
    .first_i (bg_first),
    .code_i  (cur_code),
    .errs_i  (res_errs),
    .best_o  (trk_best),
    .stop_o  (trk_stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cur_code     <= '0;
      cur_blk      <= '0;
      is_bg        <= 1'b0;
      fg_sweep     <= 1'b0;
      fg_rty       <= '0;
      bg_active    <= 1'b0;
      bg_blk       <= '0;
      bg_code      <= '0;
      bg_first     <= 1'b1;
      done_valid   <= 1'b0;
      done_ok      <= 1'b0;
      done_retries <= '0;
      done_code    <= '0;
    end else begin
      done_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_blk  <= req_block;
            fg_sweep <= req_sweep;
            is_bg    <= 1'b0;
            fg_rty   <= '0;
            state    <= ST_FG_LOOK;
          end else if (bg_active) begin
            cur_blk <= bg_blk;
            is_bg   <= 1'b1;
            if (bg_first) begin
              state <= ST_BG_LOOK;
            end else begin
              cur_code <= bg_code;
              state    <= ST_ISSUE;
            end
          end
        end
        ST_FG_LOOK: begin
          cur_code <= fg_sweep ? TOP_C : tbl_q;
          state    <= ST_ISSUE;
        end
        ST_BG_LOOK: begin
          cur_code <= tbl_q;
          state    <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (res_valid) begin
            if (!is_bg) begin
              if (res_ok || fg_rty == MAX_C || at_floor) begin
                done_valid   <= 1'b1;
                done_ok      <= res_ok;
                done_retries <= fg_rty;
                done_code    <= cur_code;
                state        <= ST_IDLE;
              end else begin
                cur_code <= nxt_code;
                fg_rty   <= fg_rty + 1'b1;
                state    <= ST_ISSUE;
              end
            end else begin
              if (trk_stop || at_floor) begin
                bg_first <= 1'b1;
                if (bg_blk == LAST_B) begin
                  bg_active <= 1'b0;
                  bg_blk    <= '0;
                end else begin
                  bg_blk <= bg_blk + 1'b1;
                end
              end else begin
                bg_first <= 1'b0;
                bg_code  <= nxt_code;
              end
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (bg_tick && !bg_active) begin
        bg_active <= 1'b1;
        bg_blk    <= '0;
        bg_first  <= 1'b1;
      end
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign bg_busy   = bg_active;
  assign rd_valid  = (state == ST_ISSUE);
  assign rd_bg     = is_bg;
  assign rd_block  = cur_blk;
  assign rd_code   = cur_code;

  // Code of the previous foreground issue, kept for the direction check.
  logic [CODE_W-1:0] fg_last_code;
  always_ff @(posedge clk) begin
    if (rst) fg_last_code <= '0;
    else if (rd_valid && !rd_bg) fg_last_code <= rd_code;
  end

  AST_STEP_ONLY_DOWN: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_bg && fg_rty != '0) |-> rd_code < fg_last_code); // R3
  AST_CODE_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_code >= FLOOR_C); // R4
  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_retries <= MAX_C); // R4
  AST_DONE_AFTER_RESULT: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(res_valid)); // R6
  AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R10
  AST_FG_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> ##2 (rd_valid && !rd_bg)); // R9
  AST_BG_ORDER: assert property (@(posedge clk) disable iff (rst)
    (bg_busy && $past(bg_busy) && bg_blk != $past(bg_blk))
      |-> bg_blk == $past(bg_blk) + 1'b1); // R7

endmodule

// File: tb/vref_retry_seq_bench.sv
module vref_retry_seq_bench;

  localparam int NB    = 8;
  localparam int CW    = 8;
  localparam int EW    = 8;
  localparam int STEP  = 4;
  localparam int FLOOR = 16;
  localparam int MAXR  = 40;
  localparam int INIT  = 160;
  localparam int TOP   = 252;
  localparam int BW    = 3;
  localparam int RW    = 6;
  localparam int LAT   = 3;
  localparam int TOL   = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [BW-1:0] req_block = '0;
  logic          req_sweep = 1'b0;
  logic          req_ready;
  logic          bg_tick = 1'b0;
  logic          bg_busy;
  logic          rd_valid, rd_bg;
  logic [BW-1:0] rd_block;
  logic [CW-1:0] rd_code;
  logic          res_valid = 1'b0;
  logic          res_ok = 1'b0;
  logic [EW-1:0] res_errs = '0;
  logic          done_valid, done_ok;
  logic [RW-1:0] done_retries;
  logic [CW-1:0] done_code;

  always #2 clk = ~clk;

  vref_retry_seq #(
    .NUM_BLOCKS (NB), .CODE_W (CW), .ERR_W (EW), .STEP (STEP), .FLOOR (FLOOR),
    .MAX_RETRY (MAXR), .INIT_CODE (INIT), .SWEEP_TOP (TOP)
  ) u_vref_retry_seq (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_block (req_block),
    .req_sweep (req_sweep), .req_ready (req_ready), .bg_tick (bg_tick),
    .bg_busy (bg_busy), .rd_valid (rd_valid), .rd_bg (rd_bg), .rd_block (rd_block),
    .rd_code (rd_code), .res_valid (res_valid), .res_ok (res_ok),
    .res_errs (res_errs), .done_valid (done_valid), .done_ok (done_ok),
    .done_retries (done_retries), .done_code (done_code)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // behavioural model state
  int opt [NB];
  int m_pred [NB];
  bit m_bact = 0;
  int m_bblk = 0, m_bcode = 0, m_best = 0, m_beste = 0, m_prev = 0, m_rises = 0;
  bit m_bfirst = 1;
  int f_blk = 0, f_code = 0, f_rty = 0;
  bit f_sweep = 0, f_first = 0, f_done = 0;
  bit last_ok = 0;
  int last_rty = 0;
  bit pd_on = 0, pd_done = 0, pd_ok = 0;
  int pd_rty = 0, pd_code = 0;
  bit pri_pending = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int err_of(input int b, input int code);
    int d = code - opt[b];
    if (d < 0) d = -d;
    d = d * 2;
    return (d > 255) ? 255 : d;
  endfunction

  task automatic answer(input int e);
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      chk("R10 no second issue", int'(rd_valid), 0);
    end
    res_valid = 1'b1;
    res_ok    = (e <= TOL);
    res_errs  = e[EW-1:0];
    @(posedge clk);
    #1;
    res_valid = 1'b0;
  endtask

  // Monitor: reference model checked on every falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (pd_on) begin
        pd_on = 0;
        chk("R6 done pulse", int'(done_valid), int'(pd_done));
        if (pd_done) begin
          chk("R4 R6 done status", int'(done_ok), int'(pd_ok));
          chk("R6 retries", int'(done_retries), pd_rty);
          chk("R6 final code", int'(done_code), pd_code);
          last_ok = pd_ok; last_rty = pd_rty; f_done = 1;
        end
      end else begin
        chk("R6 unexpected done", int'(done_valid), 0);
      end
      if (rd_valid) begin
        int e;
        e = err_of(int'(rd_block), int'(rd_code));
        if (pri_pending) chk("R9 foreground first", int'(rd_bg), 0);
        pri_pending = 0;
        if (rd_bg) begin
          int exp_code;
          chk("R7 pass running", int'(m_bact), 1);
          chk("R7 block order", int'(rd_block), m_bblk);
          exp_code = m_bfirst ? m_pred[m_bblk] : m_bcode;
          chk("R8 R9 scan code", int'(rd_code), exp_code);
          if (m_bfirst) begin
            m_best = rd_code; m_beste = e; m_prev = e; m_rises = 0;
          end else begin
            if (e < m_beste) begin m_best = rd_code; m_beste = e; end
            if (e > m_prev) m_rises++; else m_rises = 0;
            m_prev = e;
          end
          m_bfirst = 0;
          if (m_rises == 2 || int'(rd_code) < FLOOR + STEP) begin
            m_pred[m_bblk] = m_best;
            m_bfirst = 1;
            if (m_bblk == NB - 1) begin m_bact = 0; m_bblk = 0; end
            else m_bblk++;
          end else begin
            m_bcode = int'(rd_code) - STEP;
          end
          answer(e);
          pri_pending = req_valid;
          pd_on = 1; pd_done = 0;
        end else begin
          bit ok;
          if (f_first) f_code = f_sweep ? TOP : m_pred[f_blk];
          chk(f_first ? (f_sweep ? "R5 sweep start" : "R1 R2 predicted start") : "R3 step down",
              int'(rd_code), f_code);
          chk("R2 block", int'(rd_block), f_blk);
          f_first = 0;
          ok = (e <= TOL);
          answer(e);
          pd_on = 1;
          if (ok || f_rty == MAXR || f_code < FLOOR + STEP) begin
            pd_done = 1; pd_ok = ok; pd_rty = f_rty; pd_code = f_code;
          end else begin
            pd_done = 0; f_code -= STEP; f_rty++;
          end
        end
      end
    end
  end

  task automatic fg_read(input int b, input bit sweep);
    f_blk = b; f_sweep = sweep; f_first = 1; f_rty = 0; f_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_block = b[BW-1:0]; req_sweep = sweep;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!f_done) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
    bg_tick = 1'b1;
    if (!m_bact) begin m_bact = 1; m_bblk = 0; m_bfirst = 1; end
    @(negedge clk);
    bg_tick = 1'b0;
    chk("R7 busy after tick", int'(bg_busy), 1);
  endtask

  task automatic wait_pass();
    while (bg_busy) @(negedge clk);
    chk("R7 pass complete", int'(m_bact), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    int rty_pred;
    for (int b = 0; b < NB; b++) begin
      opt[b] = 100 + 3 * b;
      m_pred[b] = INIT;
    end
    opt[5] = 5;
    opt[6] = 240;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset rd_valid", int'(rd_valid), 0);
    chk("R6 reset done_valid", int'(done_valid), 0);
    chk("R7 reset bg_busy", int'(bg_busy), 0);
    chk("R9 reset req_ready", int'(req_ready), 1);

    fg_read(0, 1'b0);
    chk("R1 R6 predicted retries from init", last_rty, 14);
    chk("R6 predicted ok", int'(last_ok), 1);
    fg_read(6, 1'b1);
    chk("R5 sweep retries", last_rty, 2);
    fg_read(5, 1'b0);
    chk("R4 floor failure", int'(last_ok), 0);
    chk("R4 floor retries", last_rty, 36);
    fg_read(5, 1'b1);
    chk("R4 retry limit failure", int'(last_ok), 0);
    chk("R4 retry limit count", last_rty, MAXR);

    tick();
    repeat (20) @(negedge clk);
    fg_read(2, 1'b0);
    tick();
    repeat (10) @(negedge clk);
    fg_read(7, 1'b1);
    wait_pass();

    fg_read(1, 1'b0);
    rty_pred = last_rty;
    chk("R8 prediction near optimum", rty_pred, 0);
    fg_read(1, 1'b1);
    chk("R5 sweep retries block 1", last_rty, 36);
    chk("R8 predicted beats sweep", int'(rty_pred < last_rty), 1);

    for (int b = 0; b < NB; b++) if (b != 5 && b != 6) opt[b] -= 10;
    fg_read(3, 1'b0);
    chk("R3 drifted block retries", last_rty, 1);
    tick();
    repeat (30) @(negedge clk);
    fg_read(4, 1'b0);
    wait_pass();
    fg_read(4, 1'b0);
    chk("R8 refreshed prediction", last_rty, 0);

    repeat (10) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule